// File: doc/BRIEF.md
# Floppy Controller Host Register Front-End

This block is the host-facing register window of a two-drive floppy disk controller. A simple synchronous bus presents an address, a write byte and read and write strobes. Only the three low address bits select one of eight register slots, so the window repeats throughout the address space. Read data is combinational: it follows the address in the same cycle. Write side effects, and the pointer update caused by reading the data slot, land on the next rising clock edge.

The block holds the things a host sees and that the command engine behind it needs. These are the interrupt line with its latched status byte, the current logical drive with its mapping to a physical drive through a boot-select swap, and the command/data phase with its direction, busy flag and byte pointers. It also handles the controller reset sequence, which can optionally raise an interrupt. An alternate-platform mode input changes two things: what slot 0 returns, and whether raising an interrupt drives the line at all when DMA is disabled. The command interpreter, sector transfers, DMA and drive mechanics are not part of the block; they reach it through a few engine-side pulses and pointer outputs.

Top module: `flop_host_regs`

## Requirements
- R1: Only address bits [2:0] are decoded; any address whose low three bits match a slot behaves exactly like that slot for reads and writes.
- R2: Read values by slot: slot 1 returns 0x00; slot 6 returns 0xFF; slot 7 returns 0x00; slot 0 returns 0x00 when alt_mode is 1 and 0xFF when alt_mode is 0.
- R3: Writes act only at slots 2 (drive-output byte), 3 (tape byte, read back at slot 3), 4 (rate byte, shown on rate_sel) and 5 (data byte). Writes at slots 0, 1, 6 and 7 change no readable state.
- R4: Slot 2 reads back the last byte written there, and its bit 0 is the logical drive. phys_drive equals the logical drive XOR boot_sel.
- R5: Slot 4 reads a main status byte: bit 7 = 1 (ready), bit 6 = dir_rd, bit 4 = busy, all other bits 0.
- R6: A write at slot 5 stores the byte, increments data_len and sets busy. A read at slot 5 returns the last stored byte and increments data_pos after that edge.
- R7: A controller reset request (ctrl_rst_req) drops irq, sets the logical drive to 0, zeroes data_pos and data_len, clears busy, and enters the command phase (phase_data=0) with write direction (dir_rd=0).
- R8: A controller reset request with ctrl_rst_irq=1 then raises an interrupt with status 0xC0, under the same line gating as R9 and R10.
- R9: When not in silent mode, an irq_raise pulse asserts irq and latches irq_code into int_status. irq then stays high until irq_clear or a controller reset; a raise in the same cycle as irq_clear wins.
- R10: Silent mode is alt_mode=1 with dma_en=0. In silent mode a raise leaves irq unchanged, clears busy and still latches the status byte.
- R11: After rst_n the outputs are: irq=0, int_status=0x00, cfg_byte=0x60, ver_byte=0x90, rate_sel=0x00, slot 2 and slot 3 read 0x00, data_pos=data_len=0.
- R12: An eng_to_data pulse moves to the data phase (phase_data=1) with dir_rd taken from eng_dir_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous power-on reset |
| bus_addr | input | ADDR_W | Register address; bits [2:0] decoded |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (advances data pointer at slot 5) |
| bus_rdata | output | 8 | Combinational read data |
| alt_mode | input | 1 | Alternate-platform variant select |
| dma_en | input | 1 | DMA enabled |
| boot_sel | input | 1 | Boot-drive swap for logical-to-physical mapping |
| ctrl_rst_req | input | 1 | Controller reset pulse |
| ctrl_rst_irq | input | 1 | Raise interrupt as part of controller reset |
| irq_raise | input | 1 | Engine request to raise an interrupt |
| irq_code | input | 8 | Status byte latched on a raise |
| irq_clear | input | 1 | Engine request to drop the interrupt line |
| eng_to_data | input | 1 | Engine request to enter data phase |
| eng_dir_rd | input | 1 | Direction for the data phase (1 = to host) |
| irq | output | 1 | Interrupt line |
| int_status | output | 8 | Latched interrupt status byte |
| phys_drive | output | 1 | Selected physical drive index |
| phase_data | output | 1 | 1 = data phase, 0 = command phase |
| dir_rd | output | 1 | Transfer direction, 1 = to host |
| busy | output | 1 | Controller busy flag |
| data_pos | output | POS_W | Data read pointer |
| data_len | output | POS_W | Data byte count received |
| rate_sel | output | 8 | Rate byte from slot 4 writes |
| cfg_byte | output | 8 | Configuration value |
| ver_byte | output | 8 | Version value |

## Verification
The read map is exercised at every slot, in both platform modes and through aliased high addresses. This separates a decoder that uses the wrong bits from one that mis-assigns slots. Writes go to every dead slot with 0xFF and are then read back through the live slots. That exposes any write enable that leaks. Interrupt raises are tried in all four combinations of alt_mode and dma_en, with and without a concurrent clear, and as part of reset. This tells the silent path (status latched, busy cleared, line untouched) apart from the normal one. The drive mapping is checked with both boot_sel values against both logical drives.

// File: rtl/flop_regs_pkg.sv
package flop_regs_pkg;

  typedef enum logic [2:0] {
    SLOT_ALT  = 3'd0,
    SLOT_STB  = 3'd1,
    SLOT_DOUT = 3'd2,
    SLOT_TAPE = 3'd3,
    SLOT_MSR  = 3'd4,
    SLOT_DATA = 3'd5,
    SLOT_HOLE = 3'd6,
    SLOT_DIN  = 3'd7
  } slot_e;

  typedef struct packed {
    logic dout_we;
    logic tape_we;
    logic rate_we;
    logic data_we;
    logic data_re;
  } strobe_t;

  localparam logic [7:0] CFG_RESET      = 8'h60;
  localparam logic [7:0] VERSION_ID     = 8'h90;
  localparam logic [7:0] RESET_IRQ_CODE = 8'hC0;
  localparam logic [7:0] STATUS_B_VAL   = 8'h00;
  localparam logic [7:0] DIN_STUB       = 8'h00;
  localparam logic [7:0] OPEN_BUS       = 8'hFF;

  // main status byte: ready, direction, busy
  function automatic logic [7:0] msr_pack(input logic dir_to_host, input logic is_busy);
    return {1'b1, dir_to_host, 1'b0, is_busy, 4'b0000};
  endfunction

  // logical drive to physical drive through the boot swap
  function automatic logic phys_of(input logic logical, input logic boot);
    return logical ^ boot;
  endfunction

  // interrupt raised without driving the line
  function automatic logic irq_silent(input logic alt, input logic dma);
    return alt & ~dma;
  endfunction

  // slot 0 content depends on platform mode
  function automatic logic [7:0] slot0_value(input logic alt);
    return alt ? STATUS_B_VAL : OPEN_BUS;
  endfunction

endpackage

// File: rtl/fr_addr_dec.sv
module fr_addr_dec
  import flop_regs_pkg::*;
(
  input  logic [2:0] low_addr,
  input  logic       wr,
  input  logic       rd,
  output slot_e      slot,
  output strobe_t    stb
);

  always_comb begin
    slot        = slot_e'(low_addr);
    stb         = '0;
    stb.dout_we = wr && (slot == SLOT_DOUT);
    stb.tape_we = wr && (slot == SLOT_TAPE);
    stb.rate_we = wr && (slot == SLOT_MSR);
    stb.data_we = wr && (slot == SLOT_DATA);
    stb.data_re = rd && (slot == SLOT_DATA);
  end

endmodule

// File: rtl/fr_irq_ctl.sv
module fr_irq_ctl
  import flop_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       silent,
  input  logic       rst_req,
  input  logic       rst_irq,
  input  logic       raise,
  input  logic [7:0] code,
  input  logic       clear,
  output logic       irq,
  output logic [7:0] int_status,
  output logic       silent_raise_ev,
  output logic       line_raise_ev
);

  logic       do_raise;
  logic [7:0] code_sel;

  always_comb begin
    do_raise        = rst_req ? rst_irq : raise;
    code_sel        = rst_req ? RESET_IRQ_CODE : code;
    silent_raise_ev = do_raise && silent;
    line_raise_ev   = do_raise && !silent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      int_status <= 8'h00;
    end else begin
      if (do_raise) int_status <= code_sel;
      if (rst_req)            irq <= line_raise_ev;
      else if (line_raise_ev) irq <= 1'b1;
      else if (clear)         irq <= 1'b0;
    end
  end

endmodule

// File: rtl/fr_phase_ctl.sv
module fr_phase_ctl #(
  parameter int POS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_req,
  input  logic             data_we,
  input  logic             data_re,
  input  logic             silent_raise_ev,
  input  logic             eng_to_data,
  input  logic             eng_dir_rd,
  output logic [POS_W-1:0] data_pos,
  output logic [POS_W-1:0] data_len,
  output logic             phase_data,
  output logic             dir_rd,
  output logic             busy
);

  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || rst_req) begin
      data_pos   <= '0;
      data_len   <= '0;
      phase_data <= 1'b0;
      dir_rd     <= 1'b0;
      busy       <= 1'b0;
    end else begin
      if (data_we) data_len <= data_len + ONE;
      if (data_re) data_pos <= data_pos + ONE;
      if (eng_to_data) begin
        phase_data <= 1'b1;
        dir_rd     <= eng_dir_rd;
      end
      if (silent_raise_ev) busy <= 1'b0;
      else if (data_we)    busy <= 1'b1;
    end
  end

endmodule

// File: rtl/flop_host_regs.sv
module flop_host_regs
  import flop_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int POS_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              alt_mode,
  input  logic              dma_en,
  input  logic              boot_sel,
  input  logic              ctrl_rst_req,
  input  logic              ctrl_rst_irq,
  input  logic              irq_raise,
  input  logic [7:0]        irq_code,
  input  logic              irq_clear,
  input  logic              eng_to_data,
  input  logic              eng_dir_rd,
  output logic              irq,
  output logic [7:0]        int_status,
  output logic              phys_drive,
  output logic              phase_data,
  output logic              dir_rd,
  output logic              busy,
  output logic [POS_W-1:0]  data_pos,
  output logic [POS_W-1:0]  data_len,
  output logic [7:0]        rate_sel,
  output logic [7:0]        cfg_byte,
  output logic [7:0]        ver_byte
);

  slot_e   slot;
  strobe_t stb;
  logic    silent;
  logic    silent_raise_ev;
  logic    line_raise_ev;
  logic    logical_drive;
  logic [7:0] dout_q, tape_q, data_q;

  generate
    if (ADDR_W > 3) begin : g_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^bus_addr[ADDR_W-1:3];
    end
  endgenerate

  fr_addr_dec u_dec (
    .low_addr (bus_addr[2:0]),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .slot     (slot),
    .stb      (stb)
  );

  assign silent = irq_silent(alt_mode, dma_en);

  fr_irq_ctl u_irq (
    .clk             (clk),
    .rst_n           (rst_n),
    .silent          (silent),
    .rst_req         (ctrl_rst_req),
    .rst_irq         (ctrl_rst_irq),
    .raise           (irq_raise),
    .code            (irq_code),
    .clear           (irq_clear),
    .irq             (irq),
    .int_status      (int_status),
    .silent_raise_ev (silent_raise_ev),
    .line_raise_ev   (line_raise_ev)
  );

  fr_phase_ctl #(.POS_W(POS_W)) u_phase (
    .clk             (clk),
    .rst_n           (rst_n),
    .rst_req         (ctrl_rst_req),
    .data_we         (stb.data_we),
    .data_re         (stb.data_re),
    .silent_raise_ev (silent_raise_ev),
    .eng_to_data     (eng_to_data),
    .eng_dir_rd      (eng_dir_rd),
    .data_pos        (data_pos),
    .data_len        (data_len),
    .phase_data      (phase_data),
    .dir_rd          (dir_rd),
    .busy            (busy)
  );

  // host-written registers; controller reset forces logical drive 0
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q   <= 8'h00;
      tape_q   <= 8'h00;
      rate_sel <= 8'h00;
      data_q   <= 8'h00;
    end else begin
      if (stb.dout_we) dout_q   <= bus_wdata;
      if (stb.tape_we) tape_q   <= bus_wdata;
      if (stb.rate_we) rate_sel <= bus_wdata;
      if (stb.data_we) data_q   <= bus_wdata;
      if (ctrl_rst_req) dout_q[0] <= 1'b0;
    end
  end

  assign logical_drive = dout_q[0];
  assign phys_drive    = phys_of(logical_drive, boot_sel);
  assign cfg_byte      = CFG_RESET;
  assign ver_byte      = VERSION_ID;

  always_comb begin
    unique case (slot)
      SLOT_ALT:  bus_rdata = slot0_value(alt_mode);
      SLOT_STB:  bus_rdata = STATUS_B_VAL;
      SLOT_DOUT: bus_rdata = dout_q;
      SLOT_TAPE: bus_rdata = tape_q;
      SLOT_MSR:  bus_rdata = msr_pack(dir_rd, busy);
      SLOT_DATA: bus_rdata = data_q;
      SLOT_DIN:  bus_rdata = DIN_STUB;
      default:   bus_rdata = OPEN_BUS;
    endcase
  end

endmodule

// File: rtl/fr_chk.sv
module fr_chk #(
  parameter int POS_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       low_addr,
  input logic             bus_wr,
  input logic [7:0]       bus_rdata,
  input logic             alt_mode,
  input logic             dma_en,
  input logic             ctrl_rst_req,
  input logic             ctrl_rst_irq,
  input logic             irq_raise,
  input logic [7:0]       irq_code,
  input logic             irq_clear,
  input logic             irq,
  input logic [7:0]       int_status,
  input logic             busy,
  input logic             silent_raise_ev,
  input logic [POS_W-1:0] data_pos,
  input logic [POS_W-1:0] data_len,
  input logic             phase_data,
  input logic             dir_rd
);

  // R2
  hole_reads_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (low_addr == 3'd6) |-> (bus_rdata == 8'hFF));

  // R7
  ctrl_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rst_req && !ctrl_rst_irq) |=>
      (!irq && data_pos == '0 && data_len == '0 && !phase_data && !dir_rd && !busy));

  // R8
  reset_irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rst_req && ctrl_rst_irq && !(alt_mode && !dma_en)) |=>
      (irq && int_status == 8'hC0));

  // R9
  raise_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_raise && !ctrl_rst_req && !(alt_mode && !dma_en)) |=>
      (irq && int_status == $past(irq_code)));

  // R9
  irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clear && !ctrl_rst_req) |=> irq);

  // R10
  silent_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_raise && !ctrl_rst_req && alt_mode && !dma_en) |=>
      (irq == $past(irq) && !busy && int_status == $past(irq_code)));

  // R6
  data_write_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && low_addr == 3'd5 && !ctrl_rst_req && !silent_raise_ev) |=>
      (busy && data_len == POS_W'($past(data_len) + 1'b1)));

endmodule

bind flop_host_regs fr_chk #(.POS_W(POS_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .low_addr        (bus_addr[2:0]),
  .bus_wr          (bus_wr),
  .bus_rdata       (bus_rdata),
  .alt_mode        (alt_mode),
  .dma_en          (dma_en),
  .ctrl_rst_req    (ctrl_rst_req),
  .ctrl_rst_irq    (ctrl_rst_irq),
  .irq_raise       (irq_raise),
  .irq_code        (irq_code),
  .irq_clear       (irq_clear),
  .irq             (irq),
  .int_status      (int_status),
  .busy            (busy),
  .silent_raise_ev (silent_raise_ev),
  .data_pos        (data_pos),
  .data_len        (data_len),
  .phase_data      (phase_data),
  .dir_rd          (dir_rd)
);

// File: tb/sim_flop_host_regs.sv
`timescale 1ns/1ps
module sim_flop_host_regs;

  localparam int ADDR_W = 8;
  localparam int POS_W  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_rdata;
  logic alt_mode = 0, dma_en = 1, boot_sel = 0;
  logic ctrl_rst_req = 0, ctrl_rst_irq = 0;
  logic irq_raise = 0, irq_clear = 0;
  logic [7:0] irq_code = '0;
  logic eng_to_data = 0, eng_dir_rd = 0;
  logic irq, phys_drive, phase_data, dir_rd, busy;
  logic [7:0] int_status, rate_sel, cfg_byte, ver_byte;
  logic [POS_W-1:0] data_pos, data_len;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flop_host_regs #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .alt_mode(alt_mode), .dma_en(dma_en), .boot_sel(boot_sel),
    .ctrl_rst_req(ctrl_rst_req), .ctrl_rst_irq(ctrl_rst_irq),
    .irq_raise(irq_raise), .irq_code(irq_code), .irq_clear(irq_clear),
    .eng_to_data(eng_to_data), .eng_dir_rd(eng_dir_rd),
    .irq(irq), .int_status(int_status), .phys_drive(phys_drive),
    .phase_data(phase_data), .dir_rd(dir_rd), .busy(busy),
    .data_pos(data_pos), .data_len(data_len), .rate_sel(rate_sel),
    .cfg_byte(cfg_byte), .ver_byte(ver_byte)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  // sample combinational data then let the read strobe see one edge
  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic pulse_raise(input logic [7:0] code, input logic with_clear);
    @(negedge clk);
    irq_raise = 1; irq_code = code; irq_clear = with_clear;
    @(negedge clk);
    irq_raise = 0; irq_clear = 0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); irq_clear = 1;
    @(negedge clk); irq_clear = 0;
  endtask

  task automatic ctrl_reset(input logic with_irq);
    @(negedge clk);
    ctrl_rst_req = 1; ctrl_rst_irq = with_irq;
    @(negedge clk);
    ctrl_rst_req = 0; ctrl_rst_irq = 0;
  endtask

  task automatic t_power_on();
    logic [7:0] v;
    check("R11 irq", irq, 0);
    check("R11 int_status", int_status, 8'h00);
    check("R11 cfg", cfg_byte, 8'h60);
    check("R11 version", ver_byte, 8'h90);
    check("R11 rate", rate_sel, 8'h00);
    check("R11 data_pos", data_pos, 0);
    check("R11 data_len", data_len, 0);
    rd(8'd2, v); check("R11 slot2", v, 8'h00);
    rd(8'd3, v); check("R11 slot3", v, 8'h00);
  endtask

  task automatic t_read_map();
    logic [7:0] v;
    alt_mode = 0;
    rd(8'd0, v); check("R2 slot0 normal", v, 8'hFF);
    rd(8'd1, v); check("R2 slot1", v, 8'h00);
    rd(8'd6, v); check("R2 slot6", v, 8'hFF);
    rd(8'd7, v); check("R2 slot7", v, 8'h00);
    alt_mode = 1;
    rd(8'd0, v); check("R2 slot0 alt", v, 8'h00);
    rd(8'h28, v); check("R1 alias slot0 alt", v, 8'h00);
    alt_mode = 0;
    rd(8'h0E, v); check("R1 alias slot6", v, 8'hFF);
    rd(8'hF9, v); check("R1 alias slot1", v, 8'h00);
  endtask

  task automatic t_writes();
    logic [7:0] v;
    wr(8'd3, 8'h5A); rd(8'd3, v); check("R3 tape", v, 8'h5A);
    wr(8'd4, 8'h02); check("R3 rate", rate_sel, 8'h02);
    wr(8'd2, 8'hA4); rd(8'd2, v); check("R4 dout readback", v, 8'hA4);
    wr(8'd0, 8'hFF); wr(8'd1, 8'hFF); wr(8'd6, 8'hFF); wr(8'd7, 8'hFF);
    rd(8'd2, v); check("R3 dead writes dout", v, 8'hA4);
    rd(8'd3, v); check("R3 dead writes tape", v, 8'h5A);
    check("R3 dead writes rate", rate_sel, 8'h02);
    check("R3 dead writes len", data_len, 0);
    check("R3 dead writes busy", busy, 0);
    wr(8'h8B, 8'h3C); rd(8'd3, v); check("R1 alias write slot3", v, 8'h3C);
  endtask

  task automatic t_drive_map();
    boot_sel = 0; wr(8'd2, 8'h01); #1 check("R4 log1 boot0", phys_drive, 1);
    boot_sel = 1; #1 check("R4 log1 boot1", phys_drive, 0);
    wr(8'd2, 8'h00); #1 check("R4 log0 boot1", phys_drive, 1);
    boot_sel = 0; #1 check("R4 log0 boot0", phys_drive, 0);
  endtask

  task automatic t_data_msr();
    logic [7:0] v;
    rd(8'd4, v); check("R5 msr idle", v, 8'h80);
    wr(8'd5, 8'h11); wr(8'd5, 8'h22);
    check("R6 data_len", data_len, 2);
    check("R6 busy", busy, 1);
    rd(8'd4, v); check("R5 msr busy", v, 8'h90);
    rd(8'd5, v); check("R6 data read", v, 8'h22);
    check("R6 data_pos", data_pos, 1);
    @(negedge clk); eng_to_data = 1; eng_dir_rd = 1;
    @(negedge clk); eng_to_data = 0; eng_dir_rd = 0;
    check("R12 phase", phase_data, 1);
    check("R12 dir", dir_rd, 1);
    rd(8'd4, v); check("R5 msr dir busy", v, 8'hD0);
  endtask

  task automatic t_irq_normal();
    alt_mode = 0; dma_en = 0;
    pulse_raise(8'h20, 0);
    check("R9 line", irq, 1);
    check("R9 status", int_status, 8'h20);
    repeat (3) @(negedge clk);
    check("R9 held", irq, 1);
    pulse_clear(); check("R9 cleared", irq, 0);
    pulse_raise(8'h44, 1);
    check("R9 raise beats clear", irq, 1);
    check("R9 status 44", int_status, 8'h44);
    pulse_clear();
  endtask

  task automatic t_irq_silent();
    logic [7:0] v;
    alt_mode = 1; dma_en = 0;
    wr(8'd5, 8'h77);
    check("R10 busy before", busy, 1);
    pulse_raise(8'h31, 0);
    check("R10 line untouched", irq, 0);
    check("R10 status", int_status, 8'h31);
    check("R10 busy cleared", busy, 0);
    rd(8'd4, v); check("R10 msr", v[4], 0);
    dma_en = 1; pulse_raise(8'h32, 0);
    check("R10 alt dma on line", irq, 1);
    alt_mode = 1; dma_en = 0; pulse_raise(8'h33, 0);
    check("R10 silent keeps high line", irq, 1);
    pulse_clear();
    alt_mode = 0; dma_en = 1;
  endtask

  task automatic t_ctrl_reset();
    logic [7:0] v;
    wr(8'd2, 8'h05); wr(8'd5, 8'h10);
    @(negedge clk); eng_to_data = 1; eng_dir_rd = 1;
    @(negedge clk); eng_to_data = 0; eng_dir_rd = 0;
    pulse_raise(8'h55, 0);
    ctrl_reset(0);
    check("R7 irq", irq, 0);
    check("R7 pos", data_pos, 0);
    check("R7 len", data_len, 0);
    check("R7 phase", phase_data, 0);
    check("R7 dir", dir_rd, 0);
    check("R7 busy", busy, 0);
    rd(8'd2, v); check("R7 logical drive", v[0], 0);
    check("R7 phys", phys_drive, 0);
    ctrl_reset(1);
    check("R8 line", irq, 1);
    check("R8 status", int_status, 8'hC0);
    alt_mode = 1; dma_en = 0;
    ctrl_reset(1);
    check("R8 silent line", irq, 0);
    check("R8 silent status", int_status, 8'hC0);
    alt_mode = 0; dma_en = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_power_on();
    t_read_map();
    t_writes();
    t_drive_map();
    t_data_msr();
    t_irq_normal();
    t_irq_silent();
    t_ctrl_reset();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule